// File: doc/BRIEF.md
# Converter Clock Prescaler With Lock

This block turns an input kernel clock into a single clock-enable that is shared by a group of data converters. Software picks a 4-bit division code and a 2-bit clock-mode field through a small register. The division code selects one of twelve fixed ratios, which are not evenly spaced. The block produces a one-cycle enable pulse once every N kernel cycles. When the clock mode is anything other than zero, the divider is skipped and the enable comes straight from a bus-clock-enable input.

The division code is protected. A new code is taken only while every attached converter reports that it is idle and disabled. A code written while any converter is busy is refused, and so is a reserved code. Either case raises a sticky error flag, and software clears that flag by writing a one to its bit.

Top module: `conv_clk_prescaler`

## Requirements
- R1: After reset the register reads 0, the error flag is low, and in clock mode 00 with code 0 the enable output is high on every cycle.
- R2: Register layout for both write and read: bits [3:0] hold the division code, bits [5:4] hold the clock mode, and bit 6 is the error flag. A read returns the current state, and writing a 1 to bit 6 is a request to clear the flag.
- R3: In mode 00, code c gives a ratio N of 1,2,4,6,8,10,12,16,32,64,128,256 for c = 0..11. The enable is high for exactly one cycle in every N, and for N=1 it stays high.
- R4: A code of 12 to 15 written while no converter is busy is discarded, the previous code is kept, and the error flag is set.
- R5: A write whose code differs from the held code, made while any bit of the converter-activity vector is high, leaves the code unchanged and sets the error flag.
- R6: When every activity bit is low, a write with a legal code takes effect in the cycle after the write.
- R7: When an accepted write changes the code, the divider restarts. The first enable pulse then falls N cycles after the write cycle, in the (N-1)-th cycle after the update counted from 0, and no period is shorter than N.
- R8: When the mode field is not 00, the enable output equals the bus-clock-enable input in the same cycle and the divider is held at zero. On a return to mode 00 the pulse pattern starts afresh, as in R7.
- R9: The error flag stays high until a write with bit 6 set clears it. If the same write is itself refused, the flag stays set.
- R10: The mode field, and a write that repeats the held code, are accepted even while converters are busy, and they raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 7 | Write data (code, mode, flag clear) |
| regRdData | output | 7 | Current register contents |
| convActive | input | NUM_CONV | Per-converter busy indication (any of calibrating, starting, stopping, disabling, enabled) |
| busClkEn | input | 1 | Enable used when the mode is not 00 |
| convClkEn | output | 1 | Shared conversion clock-enable |
| errFlag | output | 1 | Sticky refused-write flag |

## Verification
If the held code is wrong, the spacing of pulses on convClkEn shows it within one period of at most 256 cycles, and the register read shows it one cycle after the write. If the divider counter is in a wrong state, the first pulse after a code change or a mode return comes early or late, so the bench counts cycles from the write. A wrong lock or error decision shows on errFlag and on the read-back code in the cycle after the write.

// File: rtl/cpre_pkg.sv
package cpre_pkg;
  localparam int CODE_W = 4;
  localparam int MODE_W = 2;
  localparam int REG_W = CODE_W + MODE_W + 1;
  localparam int CNT_W = 8;
  localparam int LAST_CODE = 11;

  typedef struct packed {
    logic restart;
    logic bypass;
    logic [CNT_W-1:0] termCnt;
  } cpre_strobe_t;

  function automatic logic [CNT_W-1:0] ratioMinusOne(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] r;
    case (c)
      4'd0: r = 8'd0;
      4'd1: r = 8'd1;
      4'd2: r = 8'd3;
      4'd3: r = 8'd5;
      4'd4: r = 8'd7;
      4'd5: r = 8'd9;
      4'd6: r = 8'd11;
      4'd7: r = 8'd15;
      4'd8: r = 8'd31;
      4'd9: r = 8'd63;
      4'd10: r = 8'd127;
      4'd11: r = 8'd255;
      default: r = 8'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cpre_ctrl.sv
module cpre_ctrl
  import cpre_pkg::*;
#(
  parameter int NUM_CONV = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [CODE_W-1:0]   wrCode,
  input  logic [MODE_W-1:0]   wrMode,
  input  logic                wrClr,
  input  logic [NUM_CONV-1:0] convActive,
  output logic [CODE_W-1:0]   codeQ,
  output logic [MODE_W-1:0]   modeQ,
  output logic                errQ,
  output cpre_strobe_t        strb
);
  logic locked, reserved, codeDiff, acceptCode, badWrite;

  assign locked     = |convActive;
  assign reserved   = (wrCode > CODE_W'(LAST_CODE));
  assign codeDiff   = (wrCode != codeQ);
  assign acceptCode = regWrEn && !locked && !reserved;
  assign badWrite   = regWrEn && ((locked && codeDiff) || (!locked && reserved));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeQ <= '0;
      modeQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (acceptCode) codeQ <= wrCode;
      if (regWrEn) modeQ <= wrMode;
      if (badWrite) errQ <= 1'b1;
      else if (regWrEn && wrClr) errQ <= 1'b0;
    end
  end

  always_comb begin
    strb.restart = acceptCode && codeDiff;
    strb.bypass  = (modeQ != '0);
    strb.termCnt = ratioMinusOne(codeQ);
  end
endmodule

// File: rtl/cpre_div.sv
module cpre_div
  import cpre_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  cpre_strobe_t strb,
  input  logic         busClkEn,
  output logic         convClkEn
);
  logic [CNT_W-1:0] cnt;
  logic tick;

  assign tick = (cnt == strb.termCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (strb.restart || strb.bypass || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign convClkEn = strb.bypass ? busClkEn : tick;
endmodule

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler
  import cpre_pkg::*;
#(
  parameter int NUM_CONV = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_CONV-1:0] convActive,
  input  logic                busClkEn,
  output logic                convClkEn,
  output logic                errFlag
);
  logic [CODE_W-1:0] codeQ;
  logic [MODE_W-1:0] modeQ;
  logic errQ;
  cpre_strobe_t strb;

  cpre_ctrl #(.NUM_CONV(NUM_CONV)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn),
    .wrCode(regWrData[CODE_W-1:0]),
    .wrMode(regWrData[CODE_W+MODE_W-1:CODE_W]),
    .wrClr(regWrData[REG_W-1]),
    .convActive(convActive),
    .codeQ(codeQ), .modeQ(modeQ), .errQ(errQ), .strb(strb)
  );

  cpre_div div_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .busClkEn(busClkEn), .convClkEn(convClkEn)
  );

  assign regRdData = {errQ, modeQ, codeQ};
  assign errFlag   = errQ;
endmodule

// File: rtl/cpre_checker.sv
module cpre_checker
  import cpre_pkg::*;
#(
  parameter int NUM_CONV = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                regWrEn,
  input logic [REG_W-1:0]    regWrData,
  input logic [NUM_CONV-1:0] convActive,
  input logic                busClkEn,
  input logic                convClkEn,
  input logic                errFlag,
  input logic [CODE_W-1:0]   codeQ,
  input logic [MODE_W-1:0]   modeQ
);
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && (|convActive)) |=> $stable(codeQ));

  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[CODE_W-1:0] > CODE_W'(LAST_CODE)) |=> ($stable(codeQ) && errFlag));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ != '0) |-> (convClkEn == busClkEn));

  p_div1_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == '0 && codeQ == '0) |-> convClkEn);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (convClkEn && modeQ == '0 && codeQ != '0 && !regWrEn) |=> !convClkEn);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !(regWrEn && regWrData[REG_W-1])) |=> errFlag);

  p_mode_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (modeQ == $past(regWrData[CODE_W+MODE_W-1:CODE_W])));
endmodule

bind conv_clk_prescaler cpre_checker #(.NUM_CONV(NUM_CONV)) chk_i (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
  .convActive(convActive), .busClkEn(busClkEn), .convClkEn(convClkEn),
  .errFlag(errFlag), .codeQ(codeQ), .modeQ(modeQ)
);

// File: tb/conv_clk_prescaler_tb.sv
module conv_clk_prescaler_tb_top;
  localparam int NC = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [6:0] regWrData = '0;
  logic [6:0] regRdData;
  logic [NC-1:0] convActive = '0;
  logic busClkEn = 1'b0;
  logic convClkEn, errFlag;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  conv_clk_prescaler #(.NUM_CONV(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .convActive(convActive), .busClkEn(busClkEn),
    .convClkEn(convClkEn), .errFlag(errFlag)
  );

  function automatic int expRatio(input int c);
    case (c)
      0: return 1;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 10;  6: return 12;  7: return 16;
      8: return 32;  9: return 64;  10: return 128; 11: return 256;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge; returns at the next negedge with the register updated
  task automatic regWrite(input logic clr, input int mode, input int code);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = {clr, 2'(mode), 4'(code)};
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  // starting at the current negedge (k=0), expect pulse when k mod n == n-1
  task automatic chkPattern(input string req, input int n, input int cycles);
    int bad = 0;
    int firstBadK = -1;
    for (int k = 0; k < cycles; k++) begin
      if (convClkEn != ((k % n) == n - 1)) begin
        bad++;
        if (firstBadK < 0) firstBadK = k;
      end
      @(negedge clk);
    end
    chk(req, bad, 0, $sformatf("pulse pattern for ratio %0d (first bad cycle %0d)", n, firstBadK));
  endtask

  task automatic t_reset();
    chk("R1", int'(regRdData), 0, "register after reset");
    chk("R1", int'(errFlag), 0, "error flag after reset");
    chkPattern("R1", 1, 6);
  endtask

  task automatic t_ratios();
    for (int c = 1; c <= 11; c++) begin
      regWrite(1'b0, 0, c);
      chk("R6", int'(regRdData[3:0]), c, "accepted code");
      chkPattern("R7", expRatio(c), 2 * expRatio(c) + 3);
    end
    regWrite(1'b0, 0, 0);
    chkPattern("R3", 1, 5);
    regWrite(1'b0, 0, 3);
    chkPattern("R3", 6, 20);
  endtask

  task automatic t_reserved();
    regWrite(1'b0, 0, 2);
    chkPattern("R2", 4, 4);
    for (int c = 12; c <= 15; c++) begin
      regWrite(1'b0, 0, c);
      chk("R4", int'(regRdData[3:0]), 2, "code after reserved write");
      chk("R4", int'(errFlag), 1, "flag after reserved write");
      regWrite(1'b1, 0, 2);
      chk("R9", int'(regRdData[6]), 0, "flag bit after clear");
    end
  endtask

  task automatic t_lock();
    for (int b = 0; b < NC; b++) begin
      @(negedge clk);
      convActive = '0;
      convActive[b] = 1'b1;
      regWrite(1'b0, 0, 5);
      chk("R5", int'(regRdData[3:0]), 2, $sformatf("code while converter %0d busy", b));
      chk("R5", int'(errFlag), 1, "flag on locked write");
      regWrite(1'b0, 0, 2);
      chk("R9", int'(errFlag), 1, "flag still set without clear");
      regWrite(1'b1, 1, 2);
      chk("R10", int'(regRdData), 7'h12, "mode taken, flag cleared while busy");
      regWrite(1'b1, 0, 7);
      chk("R9", int'(errFlag), 1, "refused write with clear keeps flag");
      regWrite(1'b1, 0, 2);
    end
    @(negedge clk);
    convActive = '0;
    regWrite(1'b0, 0, 5);
    chk("R6", int'(regRdData), 5, "code accepted after release");
    chkPattern("R7", 10, 25);
  endtask

  task automatic t_bypass();
    int bad = 0;
    regWrite(1'b0, 2, 5);
    for (int k = 0; k < 23; k++) begin
      busClkEn = ((k % 3) == 1) || (k > 17);
      #1;
      if (convClkEn != busClkEn) bad++;
      @(negedge clk);
    end
    chk("R8", bad, 0, "enable follows bus enable mismatches");
    busClkEn = 1'b0;
    regWrite(1'b0, 0, 5);
    chkPattern("R8", 10, 25);
  endtask

  initial begin
    #2000000;
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratios();
    t_reserved();
    t_lock();
    t_bypass();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule